// File: doc/BRIEF.md
# Token-Passing Transmit Sequencer

This block is the transmit sequencer for one node on a token-passing network. The host loads a destination ID and arms a transmit. Nothing goes onto the line until the node next holds the token. At that token the sequencer first asks the destination whether it has a free buffer. If the destination agrees, the sequencer sends the stored packet, which the frame transmitter follows with a 16-bit CRC. It then waits for the receiver's acknowledge and passes the token on. A refusal or a missing reply to the enquiry makes the sequencer pass the token at once. The transmit stays armed so it can be tried again at the next token.

The sequencer does not drive the line itself. It issues one-cycle request pulses to a separate frame transmitter: enquiry, packet or token pass. It waits for a `frm_done` pulse before moving on. Replies arrive already decoded as ACK, NAK or timeout pulses. Outcomes are kept in sticky status bits that the host clears by writing ones. Any status bit that is set and also enabled in the interrupt mask raises `irq`.

Top module: `token_tx_sequencer`

## Requirements
- R1: After reset all request outputs, `tx_pending`, `status` and `irq` are 0, and the interrupt mask is 0.
- R2: A `host_tx_cmd` pulse while the sequencer is idle sets `tx_pending`. It also latches `host_dest_id`, which appears on `req_dest` in the next cycle.
- R3: When idle, a `token_rx` pulse gives `req_enq` in the next cycle if `tx_pending` is 1, and `req_pass` in the next cycle if it is 0.
- R4: An ACK that answers the enquiry gives `req_pkt` in the next cycle.
- R5: A NAK that answers the enquiry gives `req_pass` with no `req_pkt`. It sets status bit 2 (refused) and leaves `tx_pending` at 1.
- R6: A timeout on the enquiry gives `req_pass` and sets status bit 3 (no reply to the enquiry). `tx_pending` stays 1, so the next token starts a new enquiry.
- R7: Once the packet is sent, an ACK sets status bit 0 (delivered) and a timeout sets status bit 1 (not delivered). In both cases `tx_pending` clears and `req_pass` follows in the next cycle.
- R8: A NAK while waiting for the acknowledge of a packet is ignored. The sequencer keeps waiting for an ACK or a timeout.
- R9: A `host_tx_cmd` that arrives while a token cycle is in progress is ignored, and `req_dest` keeps its value.
- R10: Status bits are sticky. A `host_clr_wr` pulse clears the bits where `host_clr_data` is 1. If a bit is set and cleared in the same cycle, the set wins.
- R11: `host_mask_wr` loads the interrupt mask. `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R12: Each request is a single-cycle pulse, and at most one of `req_enq`, `req_pkt` and `req_pass` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| token_rx | input | 1 | Pulse: the token has arrived at this node |
| host_tx_cmd | input | 1 | Pulse: host arms a transmit |
| host_dest_id | input | ID_W | Destination ID captured with the transmit command |
| host_mask_wr | input | 1 | Pulse: load the interrupt mask |
| host_mask_data | input | 4 | New interrupt mask value |
| host_clr_wr | input | 1 | Pulse: write-one-to-clear of status |
| host_clr_data | input | 4 | Status bits to clear |
| frm_done | input | 1 | Pulse: the frame transmitter has finished the requested frame |
| rsp_ack | input | 1 | Pulse: ACK decoded from the remote node |
| rsp_nak | input | 1 | Pulse: NAK decoded from the remote node |
| rsp_tmo | input | 1 | Pulse: response timeout expired |
| req_enq | output | 1 | Request: send a free-buffer enquiry |
| req_pkt | output | 1 | Request: send the data packet and its CRC |
| req_pass | output | 1 | Request: pass the token |
| req_dest | output | ID_W | Latched destination ID |
| tx_pending | output | 1 | Transmit armed and not yet resolved |
| status | output | 4 | Sticky status: bit0 delivered, bit1 not delivered, bit2 refused, bit3 no reply to the enquiry |
| irq | output | 1 | Interrupt: any status bit enabled by the mask |

## Verification
Every result appears one clock after the input pulse that causes it. A token, a reply or a host command is sampled on one rising edge. The request pulse, the status bit and the `tx_pending` change all show up together after that edge, and `irq` follows from the status register with no further delay. The bench drives each pulse for exactly one cycle from a falling edge. It checks the outputs at the next falling edge, and checks again one edge later to confirm that a request has already dropped. Sequences that should have no effect, such as a NAK during the acknowledge wait or a host command during a busy cycle, are checked at that same falling edge by looking for an unchanged request, status or `req_dest`.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    // Status bit positions
    localparam int NSTAT      = 4;
    localparam int ST_OK      = 0;
    localparam int ST_FAIL    = 1;
    localparam int ST_REFUSED = 2;
    localparam int ST_NOREPLY = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENQ_TX,
        S_ENQ_WAIT,
        S_PKT_TX,
        S_ACK_WAIT,
        S_PASS_TX
    } seq_state_e;

    typedef struct packed {
        logic enq;
        logic pkt;
        logic pass;
    } frame_req_t;

    typedef struct packed {
        logic ack;
        logic nak;
        logic tmo;
    } resp_t;

    typedef enum logic [1:0] {
        RSP_NONE,
        RSP_ACK,
        RSP_NAK,
        RSP_TMO
    } resp_kind_e;

    // ACK outranks NAK, NAK outranks timeout
    function automatic resp_kind_e classify(resp_t r);
        if (r.ack)      return RSP_ACK;
        else if (r.nak) return RSP_NAK;
        else if (r.tmo) return RSP_TMO;
        else            return RSP_NONE;
    endfunction

    function automatic logic any_enabled(logic [NSTAT-1:0] s, logic [NSTAT-1:0] m);
        return |(s & m);
    endfunction

endpackage

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
    import txseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             token_rx,
    input  logic             tx_pending,
    input  logic             frm_done,
    input  resp_t            rsp,
    output frame_req_t       req,
    output logic [NSTAT-1:0] evt,
    output logic             delivered,
    output logic             busy
);

    seq_state_e state, state_nx;
    frame_req_t req_nx;
    resp_kind_e kind;

    assign kind = classify(rsp);
    assign busy = (state != S_IDLE);

    always_comb begin
        state_nx  = state;
        req_nx    = '0;
        evt       = '0;
        delivered = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (token_rx) begin
                    if (tx_pending) begin
                        state_nx   = S_ENQ_TX;
                        req_nx.enq = 1'b1;
                    end else begin
                        state_nx    = S_PASS_TX;
                        req_nx.pass = 1'b1;
                    end
                end
            end
            S_ENQ_TX: if (frm_done) state_nx = S_ENQ_WAIT;
            S_ENQ_WAIT: begin
                unique case (kind)
                    RSP_ACK: begin
                        state_nx   = S_PKT_TX;
                        req_nx.pkt = 1'b1;
                    end
                    RSP_NAK: begin
                        state_nx        = S_PASS_TX;
                        req_nx.pass     = 1'b1;
                        evt[ST_REFUSED] = 1'b1;
                    end
                    RSP_TMO: begin
                        state_nx        = S_PASS_TX;
                        req_nx.pass     = 1'b1;
                        evt[ST_NOREPLY] = 1'b1;
                    end
                    default: ;
                endcase
            end
            S_PKT_TX: if (frm_done) state_nx = S_ACK_WAIT;
            S_ACK_WAIT: begin
                // a NAK here is not a conclusion: keep waiting
                if (kind == RSP_ACK) begin
                    state_nx    = S_PASS_TX;
                    req_nx.pass = 1'b1;
                    evt[ST_OK]  = 1'b1;
                    delivered   = 1'b1;
                end else if (rsp.tmo) begin
                    state_nx     = S_PASS_TX;
                    req_nx.pass  = 1'b1;
                    evt[ST_FAIL] = 1'b1;
                    delivered    = 1'b1;
                end
            end
            S_PASS_TX: if (frm_done) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            req   <= '0;
        end else begin
            state <= state_nx;
            req   <= req_nx;
        end
    end

    // R12
    req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.enq, req.pkt, req.pass}));

    // R12
    pass_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req.pass |=> !req.pass);

    // R3
    token_enq_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && token_rx && tx_pending) |=> req.enq);

    // R4
    pkt_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req.pkt) |-> $past(rsp.ack));

    // R8
    nak_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_ACK_WAIT && rsp.nak && !rsp.ack && !rsp.tmo) |=> (state == S_ACK_WAIT && !req.pass));

endmodule

// File: rtl/txseq_host_if.sv
module txseq_host_if
    import txseq_pkg::*;
#(
    parameter int ID_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [ID_W-1:0]  cmd_dest,
    input  logic             busy,
    input  logic             delivered,
    input  logic             mask_wr,
    input  logic [NSTAT-1:0] mask_data,
    output logic             pending,
    output logic [ID_W-1:0]  dest,
    output logic [NSTAT-1:0] mask
);

    logic accept;
    assign accept = cmd_wr && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            dest    <= '0;
            mask    <= '0;
        end else begin
            if (delivered)   pending <= 1'b0;
            else if (accept) pending <= 1'b1;
            if (accept)      dest    <= cmd_dest;
            if (mask_wr)     mask    <= mask_data;
        end
    end

    // R9
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> $stable(dest));

    // R7
    pending_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        delivered |=> !pending);

endmodule

// File: rtl/txseq_status.sv
module txseq_status
    import txseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] set,
    input  logic             clr_wr,
    input  logic [NSTAT-1:0] clr_data,
    input  logic [NSTAT-1:0] mask,
    output logic [NSTAT-1:0] stat,
    output logic             irq
);

    for (genvar i = 0; i < NSTAT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                       stat[i] <= 1'b0;
            else if (set[i])               stat[i] <= 1'b1;
            else if (clr_wr && clr_data[i]) stat[i] <= 1'b0;
        end

        // R10
        sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (stat[i] && !(clr_wr && clr_data[i])) |=> stat[i]);
    end

    assign irq = any_enabled(stat, mask);

endmodule

// File: rtl/token_tx_sequencer.sv
module token_tx_sequencer
    import txseq_pkg::*;
#(
    parameter int ID_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             token_rx,
    input  logic             host_tx_cmd,
    input  logic [ID_W-1:0]  host_dest_id,
    input  logic             host_mask_wr,
    input  logic [NSTAT-1:0] host_mask_data,
    input  logic             host_clr_wr,
    input  logic [NSTAT-1:0] host_clr_data,
    input  logic             frm_done,
    input  logic             rsp_ack,
    input  logic             rsp_nak,
    input  logic             rsp_tmo,
    output logic             req_enq,
    output logic             req_pkt,
    output logic             req_pass,
    output logic [ID_W-1:0]  req_dest,
    output logic             tx_pending,
    output logic [NSTAT-1:0] status,
    output logic             irq
);

    resp_t            rsp;
    frame_req_t       req;
    logic [NSTAT-1:0] evt;
    logic [NSTAT-1:0] mask;
    logic             delivered;
    logic             busy;

    assign rsp = '{ack: rsp_ack, nak: rsp_nak, tmo: rsp_tmo};

    txseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .token_rx   (token_rx),
        .tx_pending (tx_pending),
        .frm_done   (frm_done),
        .rsp        (rsp),
        .req        (req),
        .evt        (evt),
        .delivered  (delivered),
        .busy       (busy)
    );

    txseq_host_if #(.ID_W(ID_W)) u_host (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (host_tx_cmd),
        .cmd_dest   (host_dest_id),
        .busy       (busy),
        .delivered  (delivered),
        .mask_wr    (host_mask_wr),
        .mask_data  (host_mask_data),
        .pending    (tx_pending),
        .dest       (req_dest),
        .mask       (mask)
    );

    txseq_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .set        (evt),
        .clr_wr     (host_clr_wr),
        .clr_data   (host_clr_data),
        .mask       (mask),
        .stat       (status),
        .irq        (irq)
    );

    assign req_enq  = req.enq;
    assign req_pkt  = req.pkt;
    assign req_pass = req.pass;

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

endmodule

// File: tb/tb_token_tx_sequencer.sv
`timescale 1ns/1ps
module tb_token_tx_sequencer;

    localparam int ID_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic token_rx = 0, host_tx_cmd = 0, host_mask_wr = 0, host_clr_wr = 0;
    logic [ID_W-1:0] host_dest_id = '0;
    logic [3:0] host_mask_data = '0, host_clr_data = '0;
    logic frm_done = 0, rsp_ack = 0, rsp_nak = 0, rsp_tmo = 0;
    logic req_enq, req_pkt, req_pass, tx_pending, irq;
    logic [ID_W-1:0] req_dest;
    logic [3:0] status;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    token_tx_sequencer #(.ID_W(ID_W)) dut (
        .clk(clk), .rst(rst), .token_rx(token_rx), .host_tx_cmd(host_tx_cmd),
        .host_dest_id(host_dest_id), .host_mask_wr(host_mask_wr),
        .host_mask_data(host_mask_data), .host_clr_wr(host_clr_wr),
        .host_clr_data(host_clr_data), .frm_done(frm_done), .rsp_ack(rsp_ack),
        .rsp_nak(rsp_nak), .rsp_tmo(rsp_tmo), .req_enq(req_enq), .req_pkt(req_pkt),
        .req_pass(req_pass), .req_dest(req_dest), .tx_pending(tx_pending),
        .status(status), .irq(irq)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // one-cycle pulse: 0 token, 1 frm_done, 2 ack, 3 nak, 4 tmo
    task automatic strobe(int which);
        case (which)
            0: token_rx = 1;
            1: frm_done = 1;
            2: rsp_ack  = 1;
            3: rsp_nak  = 1;
            default: rsp_tmo = 1;
        endcase
        @(negedge clk);
        token_rx = 0; frm_done = 0; rsp_ack = 0; rsp_nak = 0; rsp_tmo = 0;
    endtask

    task automatic host_cmd(logic [ID_W-1:0] d);
        host_tx_cmd = 1; host_dest_id = d;
        @(negedge clk);
        host_tx_cmd = 0;
    endtask

    task automatic clear_all();
        host_clr_wr = 1; host_clr_data = 4'hF;
        @(negedge clk);
        host_clr_wr = 0; host_clr_data = '0;
        chk("R10", "status after w1c", status, 0);
    endtask

    task automatic t_reset();
        chk("R1", "req_enq", req_enq, 0);
        chk("R1", "req_pkt", req_pkt, 0);
        chk("R1", "req_pass", req_pass, 0);
        chk("R1", "tx_pending", tx_pending, 0);
        chk("R1", "status", status, 0);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_no_pending();
        strobe(0);
        chk("R3", "req_pass on idle token", req_pass, 1);
        chk("R3", "req_enq on idle token", req_enq, 0);
        @(negedge clk);
        chk("R12", "req_pass single cycle", req_pass, 0);
        strobe(1);
    endtask

    task automatic t_success();
        host_cmd(8'h5A);
        chk("R2", "tx_pending", tx_pending, 1);
        chk("R2", "req_dest", req_dest, 8'h5A);
        strobe(0);
        chk("R3", "req_enq", req_enq, 1);
        chk("R12", "no pass with enq", req_pass, 0);
        strobe(1);
        chk("R12", "req_enq dropped", req_enq, 0);
        strobe(2);
        chk("R4", "req_pkt after enquiry ACK", req_pkt, 1);
        host_cmd(8'h33);
        chk("R9", "req_dest kept while busy", req_dest, 8'h5A);
        strobe(1);
        // set and clear of the same bit in one cycle: the set wins
        host_clr_wr = 1; host_clr_data = 4'b0001;
        strobe(2);
        host_clr_wr = 0; host_clr_data = '0;
        chk("R7", "req_pass after delivery", req_pass, 1);
        chk("R7", "tx_pending cleared", tx_pending, 0);
        chk("R10", "delivered bit set wins", status, 4'b0001);
        strobe(1);
        clear_all();
    endtask

    task automatic t_enq_nak();
        host_cmd(8'h22);
        strobe(0);
        strobe(1);
        strobe(3);
        chk("R5", "req_pass after NAK", req_pass, 1);
        chk("R5", "no req_pkt", req_pkt, 0);
        chk("R5", "refused bit", status, 4'b0100);
        chk("R5", "pending kept", tx_pending, 1);
        strobe(1);
        clear_all();
    endtask

    task automatic t_enq_timeout();
        strobe(0);
        chk("R6", "enquiry for pending", req_enq, 1);
        strobe(1);
        strobe(4);
        chk("R6", "req_pass after timeout", req_pass, 1);
        chk("R6", "no-reply bit", status, 4'b1000);
        chk("R6", "pending kept", tx_pending, 1);
        strobe(1);
        strobe(0);
        chk("R6", "retry enquiry at next token", req_enq, 1);
        strobe(1);
        strobe(2);
        strobe(1);
        strobe(2);
        chk("R7", "delivered after retry", status[0], 1);
        strobe(1);
        clear_all();
    endtask

    task automatic t_no_ack();
        host_cmd(8'h11);
        strobe(0);
        strobe(1);
        strobe(2);
        strobe(1);
        strobe(3);
        chk("R8", "no pass after NAK in ack wait", req_pass, 0);
        chk("R8", "status unchanged", status, 0);
        strobe(4);
        chk("R7", "req_pass after ack timeout", req_pass, 1);
        chk("R7", "not-delivered bit", status, 4'b0010);
        chk("R7", "pending cleared", tx_pending, 0);
        strobe(1);
    endtask

    task automatic t_irq();
        chk("R11", "irq with zero mask", irq, 0);
        host_mask_wr = 1; host_mask_data = 4'b0010;
        @(negedge clk);
        host_mask_wr = 0;
        chk("R11", "irq with matching mask", irq, 1);
        host_mask_wr = 1; host_mask_data = 4'b1101;
        @(negedge clk);
        host_mask_wr = 0;
        chk("R11", "irq with other bits masked", irq, 0);
        host_mask_wr = 1; host_mask_data = 4'b0010;
        @(negedge clk);
        host_mask_wr = 0;
        host_clr_wr = 1; host_clr_data = 4'b0010;
        @(negedge clk);
        host_clr_wr = 0;
        chk("R10", "bit cleared by w1c", status, 0);
        chk("R11", "irq after clear", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_no_pending();
        t_success();
        t_enq_nak();
        t_enq_timeout();
        t_no_ack();
        t_irq();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule